// File: doc/BRIEF.md
# USB Receive Bit-Stuff Error and Retry Countdown

This block sits behind the line decoder of a USB host port and watches the received bit stream. A bit counts only when its valid strobe is high. When too many one bits arrive in a row inside a packet, the block reports a bit-stuffing violation. The violation also decrements a small retry countdown that belongs to the transfer descriptor now being worked on.

When that countdown steps from one to zero, the descriptor is retired. Its active flag drops and its stalled flag rises. The block does not raise the error status bit at that moment. It holds the event as pending and moves it into the status bit at the next frame-end strobe. The status bit drives the interrupt request, and software clears it by writing a one. The descriptor controller loads the countdown and flags through a load port. It reads the updated values back from the writeback outputs.

Top module: `usb_stuff_retry`

## Requirements
- R1: A run of seven one bits with `rx_valid` high, inside one packet (`pkt_active` high), pulses `stuff_err` for one cycle. The pulse appears in the cycle after the seventh bit is sampled. A run of six ones gives no pulse.
- R2: Each violation seen while the descriptor is active and its count is nonzero lowers `desc_errs` by exactly one, in the same cycle as the `stuff_err` pulse.
- R3: When a violation takes the count from 1 to 0, `desc_active` becomes 0 and `desc_stalled` becomes 1.
- R4: A `desc_load` cycle copies `ld_errs` into `desc_errs` and `ld_active` into `desc_active`, and it clears `desc_stalled`. The load wins over a violation in the same cycle, although `stuff_err` still pulses.
- R5: A count of 0 on an active descriptor means unlimited retries. Violations leave the count at 0 and the descriptor active.
- R6: `err_sts` rises only in the cycle after a `frame_end` strobe. That strobe is the first one that arrives in or after the cycle in which the descriptor retired. Retirement alone does not set it.
- R7: `irq` is high exactly while `err_sts` is high.
- R8: The run of ones restarts on a valid zero bit and whenever `pkt_active` is low. Cycles with `rx_valid` low neither add to the run nor break it.
- R9: At most one violation is counted per packet, however long the run of ones continues.
- R10: A cycle with `sts_clr` high clears `err_sts`. If a frame-end set happens in the same cycle, the set wins.
- R11: Violations against an inactive descriptor leave `desc_errs`, `desc_active` and `desc_stalled` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Decoded received bit |
| rx_valid | input | 1 | `rx_bit` carries a bit this cycle |
| pkt_active | input | 1 | High for the length of a received packet |
| desc_load | input | 1 | Load descriptor state from `ld_*` |
| ld_errs | input | 2 | Retry count to load |
| ld_active | input | 1 | Active flag to load |
| frame_end | input | 1 | One-cycle frame boundary strobe |
| sts_clr | input | 1 | Software write-one-to-clear of `err_sts` |
| stuff_err | output | 1 | One-cycle bit-stuff violation pulse |
| desc_errs | output | 2 | Writeback: remaining retry count |
| desc_active | output | 1 | Writeback: descriptor active |
| desc_stalled | output | 1 | Writeback: descriptor stalled |
| err_sts | output | 1 | Error interrupt status bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives runs of exactly six and exactly seven ones. These show where the violation threshold lies. A zero inside a run, a gap in the valid strobe and a packet boundary inside a run each check a different part of the restart rule for the run. Runs that continue far past seven, and violations against an inactive descriptor, a zero count and a load in the same cycle, show whether the countdown moves only when it should. A frame-end strobe that comes late and one that coincides with a software clear check how the deferred status bit is timed and which side has priority.

// File: rtl/usb_stuff_pkg.sv
package usb_stuff_pkg;
    localparam int ERR_CNT_W       = 2;
    localparam int STUFF_LIMIT_DEF = 6;

    typedef logic [ERR_CNT_W-1:0] errs_t;

    typedef struct packed {
        errs_t errs;
        logic  active;
        logic  stalled;
    } td_state_t;

    function automatic logic last_try(errs_t c);
        return c == errs_t'(1);
    endfunction
endpackage

// File: rtl/ones_run_mon.sv
module ones_run_mon #(
    parameter int STUFF_LIMIT = usb_stuff_pkg::STUFF_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    input  logic rx_valid,
    input  logic pkt_active,
    output logic stuff_hit
);
    localparam int RUN_MAX = STUFF_LIMIT + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic [RUN_W-1:0] run;
    logic             flagged;

    assign stuff_hit = pkt_active && rx_valid && rx_bit && !flagged
                       && (run == RUN_W'(STUFF_LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !pkt_active) begin
            run     <= '0;
            flagged <= 1'b0;
        end else begin
            if (rx_valid) begin
                if (!rx_bit)
                    run <= '0;
                else if (run != RUN_W'(RUN_MAX))
                    run <= run + 1'b1;
            end
            if (stuff_hit)
                flagged <= 1'b1;
        end
    end
endmodule

// File: rtl/td_err_track.sv
module td_err_track
    import usb_stuff_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      desc_load,
    input  errs_t     ld_errs,
    input  logic      ld_active,
    input  logic      stuff_hit,
    output td_state_t td,
    output logic      retire
);
    logic charge;

    assign charge = stuff_hit && !desc_load && td.active && (td.errs != '0);
    assign retire = charge && last_try(td.errs);

    always_ff @(posedge clk) begin
        if (rst) begin
            td <= '0;
        end else if (desc_load) begin
            td.errs    <= ld_errs;
            td.active  <= ld_active;
            td.stalled <= 1'b0;
        end else if (charge) begin
            td.errs <= td.errs - 1'b1;
            if (retire) begin
                td.active  <= 1'b0;
                td.stalled <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_irq_gate.sv
module frame_irq_gate (
    input  logic clk,
    input  logic rst,
    input  logic retire,
    input  logic frame_end,
    input  logic sts_clr,
    output logic err_sts,
    output logic irq
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            err_sts <= 1'b0;
        end else begin
            if (frame_end) begin
                pend <= 1'b0;
                if (pend || retire)
                    err_sts <= 1'b1;
                else if (sts_clr)
                    err_sts <= 1'b0;
            end else begin
                if (retire)
                    pend <= 1'b1;
                if (sts_clr)
                    err_sts <= 1'b0;
            end
        end
    end

    assign irq = err_sts;
endmodule

// File: rtl/usb_stuff_retry.sv
module usb_stuff_retry
    import usb_stuff_pkg::*;
#(
    parameter int STUFF_LIMIT = STUFF_LIMIT_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_bit,
    input  logic                 rx_valid,
    input  logic                 pkt_active,
    input  logic                 desc_load,
    input  logic [ERR_CNT_W-1:0] ld_errs,
    input  logic                 ld_active,
    input  logic                 frame_end,
    input  logic                 sts_clr,
    output logic                 stuff_err,
    output logic [ERR_CNT_W-1:0] desc_errs,
    output logic                 desc_active,
    output logic                 desc_stalled,
    output logic                 err_sts,
    output logic                 irq
);
    logic      hit;
    logic      retire;
    td_state_t td;

    ones_run_mon #(.STUFF_LIMIT(STUFF_LIMIT)) u_run (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .pkt_active(pkt_active), .stuff_hit(hit)
    );

    td_err_track u_td (
        .clk(clk), .rst(rst), .desc_load(desc_load), .ld_errs(ld_errs),
        .ld_active(ld_active), .stuff_hit(hit), .td(td), .retire(retire)
    );

    frame_irq_gate u_irq (
        .clk(clk), .rst(rst), .retire(retire), .frame_end(frame_end),
        .sts_clr(sts_clr), .err_sts(err_sts), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) stuff_err <= 1'b0;
        else     stuff_err <= hit;
    end

    assign desc_errs    = td.errs;
    assign desc_active  = td.active;
    assign desc_stalled = td.stalled;
endmodule

// File: rtl/usb_stuff_retry_chk.sv
module usb_stuff_retry_chk (
    input logic       clk,
    input logic       rst,
    input logic       desc_load,
    input logic       frame_end,
    input logic       stuff_err,
    input logic [1:0] desc_errs,
    input logic       desc_active,
    input logic       desc_stalled,
    input logic       err_sts
);
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (!desc_load && desc_errs != 2'd0) |=>
        (desc_errs == $past(desc_errs) || desc_errs == $past(desc_errs) - 2'd1)); // R2

    AST_STALL_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        desc_stalled |-> !desc_active); // R3

    AST_ZERO_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (!desc_load && desc_errs == 2'd0 && desc_active) |=> (desc_active && desc_errs == 2'd0)); // R5

    AST_STS_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(err_sts) |-> $past(frame_end)); // R6

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        stuff_err |=> !stuff_err); // R9
endmodule

bind usb_stuff_retry usb_stuff_retry_chk u_chk (
    .clk(clk), .rst(rst), .desc_load(desc_load), .frame_end(frame_end),
    .stuff_err(stuff_err), .desc_errs(desc_errs), .desc_active(desc_active),
    .desc_stalled(desc_stalled), .err_sts(err_sts)
);

// File: tb/tb_usb_stuff_retry.sv
`timescale 1ns/1ps
module tb_usb_stuff_retry;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0, rx_valid = 1'b0, pkt_active = 1'b0;
    logic desc_load = 1'b0, ld_active = 1'b0, frame_end = 1'b0, sts_clr = 1'b0;
    logic [1:0] ld_errs = 2'd0;
    logic stuff_err, desc_active, desc_stalled, err_sts, irq;
    logic [1:0] desc_errs;

    int total = 0;
    int bad = 0;
    bit running = 1'b0;

    // behavioural reference state
    int m_run = 0, m_cnt = 0;
    bit m_seen = 0, m_act = 0, m_stl = 0, m_pend = 0, m_sts = 0, m_serr = 0;

    usb_stuff_retry dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .pkt_active(pkt_active), .desc_load(desc_load), .ld_errs(ld_errs),
        .ld_active(ld_active), .frame_end(frame_end), .sts_clr(sts_clr),
        .stuff_err(stuff_err), .desc_errs(desc_errs), .desc_active(desc_active),
        .desc_stalled(desc_stalled), .err_sts(err_sts), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        bit viol, ret;
        viol = 0; ret = 0;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_seen = 0; m_act = 0; m_stl = 0;
            m_pend = 0; m_sts = 0; m_serr = 0;
        end else begin
            if (!pkt_active) begin
                m_run = 0; m_seen = 0;
            end else if (rx_valid) begin
                if (rx_bit) begin
                    if (m_run == 6 && !m_seen) begin viol = 1; m_seen = 1; end
                    if (m_run < 7) m_run++;
                end else m_run = 0;
            end
            m_serr = viol;
            if (desc_load) begin
                m_cnt = ld_errs; m_act = ld_active; m_stl = 0;
            end else if (viol && m_act && m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin m_act = 0; m_stl = 1; ret = 1; end
            end
            if (frame_end) begin
                if (m_pend || ret) m_sts = 1;
                else if (sts_clr) m_sts = 0;
                m_pend = 0;
            end else begin
                if (ret) m_pend = 1;
                if (sts_clr) m_sts = 0;
            end
        end
    end

    task automatic expect_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            expect_eq("R1 stuff_err", stuff_err, m_serr);
            expect_eq("R2 desc_errs", desc_errs, m_cnt);
            expect_eq("R3 desc_active", desc_active, m_act);
            expect_eq("R3 desc_stalled", desc_stalled, m_stl);
            expect_eq("R6 err_sts", err_sts, m_sts);
            expect_eq("R7 irq", irq, m_sts);
        end
    end

    task automatic tick();
        @(negedge clk);
        rx_valid = 0; rx_bit = 0; frame_end = 0; sts_clr = 0; desc_load = 0;
    endtask
    task automatic send(bit b);
        tick(); rx_valid = 1; rx_bit = b;
    endtask
    task automatic ones(int n);
        for (int i = 0; i < n; i++) send(1);
    endtask
    task automatic pkt_on();
        tick(); pkt_active = 1;
    endtask
    task automatic pkt_off();
        tick(); pkt_active = 0;
    endtask
    task automatic load(int c, bit a);
        tick(); desc_load = 1; ld_errs = 2'(c); ld_active = a;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        tick();
        // reset state
        expect_eq("R4 reset errs", desc_errs, 0);
        expect_eq("R4 reset active", desc_active, 0);
        expect_eq("R6 reset sts", err_sts, 0);

        // R8: zero inside run restarts it; six ones never trigger (R1)
        load(3, 1);
        pkt_on(); ones(6); send(0); ones(6); tick();
        expect_eq("R8 zero restarts run", desc_errs, 3);
        expect_eq("R1 six ones no pulse", stuff_err, 0);
        pkt_off();

        // R1/R2 seventh one, R9 long run only one decrement
        pkt_on(); ones(7); tick();
        expect_eq("R1 pulse after seventh", stuff_err, 1);
        expect_eq("R2 one decrement", desc_errs, 2);
        ones(5); tick();
        expect_eq("R9 no second decrement", desc_errs, 2);
        pkt_off();

        // R8: invalid cycles neither add nor break
        pkt_on(); ones(3); tick(); tick(); ones(4); tick();
        expect_eq("R8 gap ignored", desc_errs, 1);
        pkt_off();

        // R8: packet boundary restarts run
        pkt_on(); ones(4); pkt_off(); pkt_on(); ones(3); tick();
        expect_eq("R8 packet restart", desc_errs, 1);
        pkt_off();

        // R3 retire, R6 deferred status, R7 irq
        pkt_on(); ones(7); tick();
        expect_eq("R3 errs zero", desc_errs, 0);
        expect_eq("R3 inactive", desc_active, 0);
        expect_eq("R3 stalled", desc_stalled, 1);
        expect_eq("R6 not yet set", err_sts, 0);
        pkt_off(); tick(); tick();
        expect_eq("R6 still pending", err_sts, 0);
        tick(); frame_end = 1; tick();
        expect_eq("R6 set at frame end", err_sts, 1);
        expect_eq("R7 irq raised", irq, 1);

        // R11: inactive descriptor untouched
        pkt_on(); ones(7); tick();
        expect_eq("R11 errs kept", desc_errs, 0);
        expect_eq("R11 stall kept", desc_stalled, 1);
        pkt_off();

        // R10 clear
        tick(); sts_clr = 1; tick();
        expect_eq("R10 cleared", err_sts, 0);
        expect_eq("R7 irq dropped", irq, 0);

        // R10 set beats clear in same cycle (R6 same-cycle frame end)
        load(1, 1); pkt_on(); ones(6);
        tick(); rx_valid = 1; rx_bit = 1; frame_end = 1; sts_clr = 1; tick();
        expect_eq("R10 set wins", err_sts, 1);
        pkt_off(); tick(); sts_clr = 1; tick();

        // R5 unlimited retries
        load(0, 1); pkt_on(); ones(9); pkt_off(); pkt_on(); ones(7); tick();
        expect_eq("R5 errs stay zero", desc_errs, 0);
        expect_eq("R5 stays active", desc_active, 1);
        expect_eq("R5 not stalled", desc_stalled, 0);
        pkt_off();

        // R4 load beats violation
        load(1, 1); pkt_on(); ones(6);
        tick(); rx_valid = 1; rx_bit = 1; desc_load = 1; ld_errs = 2'd2; ld_active = 1; tick();
        expect_eq("R4 load wins errs", desc_errs, 2);
        expect_eq("R4 load wins active", desc_active, 1);
        expect_eq("R4 pulse still", stuff_err, 1);
        pkt_off();
        load(3, 0); tick();
        expect_eq("R4 load inactive", desc_active, 0);
        expect_eq("R4 load errs", desc_errs, 3);
        tick(); tick();

        running = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule